// File: doc/BRIEF.md
# Capability Revocation Sweep Engine

This block walks a range of tagged memory in the background, one 8-byte capability granule at a time, and removes the validity tag from every capability whose base address is marked revoked. For each granule it reads the stored word and its tag. When the tag is set, it fetches the revocation-bitmap word that covers the capability's base address and tests the bit for that base's granule. When the bit is set, it writes the same word back with the tag cleared. Untagged granules, and capabilities whose base is not revoked, are left alone.

Software drives the engine through a small 32-bit register window. It sets a start address and an exclusive end address, then writes the go command. It can poll a running flag, which sits in bit 0 of a word whose upper bits count sweep boundaries. On completion the engine raises a sticky status bit, which reaches the interrupt line only when the enable bit is set. The capability base is taken as one fixed 32-bit field of the stored word.

Top module: `cap_sweep_engine`

## Requirements
- R1: After reset, the start, end and enable registers read 0. The status word (offset 12) reads 0, the interrupt status (offset 16) reads 0, and `irq` is 0.
- R2: Offsets 0, 4 and 20 read back the value last written (bit 0 only at offset 20). Offset 8, and any offset outside 0..20, reads 0.
- R3: A write to offset 8 with bit 0 set, while idle, makes bit 0 of offset 12 read 1 on the next cycle. Bits 31:1 of offset 12 advance by one at that start and by one more when the sweep finishes.
- R4: The engine reads granules at 8-byte steps, in ascending order. It begins at the start address with its low 3 bits forced to 0 and reads every granule whose address is below the end address, each exactly once.
- R5: A granule is cleared when its tag is 1 and the bitmap bit for its base is set. The base is bits 31:0 of the stored word. The bitmap word index is base[31:8] and the bit is base[7:3], so an all-ones bitmap word revokes 32 granules. Clearing writes the unchanged data back with tag 0, at the granule's address, two cycles after that granule's read.
- R6: No write is made to an untagged granule, nor to a capability whose bitmap bit is clear; both keep their data and tag.
- R7: Finishing a sweep sets interrupt status bit 0. A write to offset 16 with bit 0 clear clears it, unless a sweep finishes in that same cycle, in which case the status stays 1.
- R8: `irq` is 1 exactly when interrupt status bit 0 and enable bit 0 (offset 20) are both 1.
- R9: A start command written while the running flag is 1 has no effect: the epoch count does not change and the sweep is not restarted.
- R10: If the end address is not above the aligned start address, the sweep finishes one cycle after it starts. It makes no memory or bitmap access, and the epoch still advances by two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Tagged-memory access this cycle |
| mem_we | output | 1 | Access is a write (with `mem_req`) |
| mem_addr | output | 32 | Byte address of the granule |
| mem_wdata | output | 64 | Data written back |
| mem_wtag | output | 1 | Tag written back |
| mem_rdata | input | 64 | Read data, one cycle after a read request |
| mem_rtag | input | 1 | Tag of the read granule, same timing |
| rev_req | output | 1 | Bitmap read request |
| rev_addr | output | 24 | Bitmap word index |
| rev_rdata | input | 32 | Bitmap word, one cycle after the request |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to produce is a software acknowledge that lands on the exact cycle a sweep finishes, because an ordinary sweep's length depends on memory contents. The bench uses an empty range, whose completion falls exactly one cycle after the go write, and places the status-clear write on that cycle. A restart attempt in the middle of a running sweep is also placed directly. Randomised memory images, tags, bases and sparse bitmaps, under a fixed seed, exercise the mix of kept and cleared granules over many ranges, including unaligned start addresses.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    localparam int ADDR_W  = 32;
    localparam int GRAN_LG = 3;
    localparam int MAPW_LG = 5;
    localparam int REV_AW  = ADDR_W - GRAN_LG - MAPW_LG;
    localparam int REG_AW  = 5;

    localparam logic [REG_AW-1:0] OFF_FROM  = 5'd0;
    localparam logic [REG_AW-1:0] OFF_UPTO  = 5'd4;
    localparam logic [REG_AW-1:0] OFF_GO    = 5'd8;
    localparam logic [REG_AW-1:0] OFF_EPOCH = 5'd12;
    localparam logic [REG_AW-1:0] OFF_ISTAT = 5'd16;
    localparam logic [REG_AW-1:0] OFF_IEN   = 5'd20;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_CHECK = 2'd1,
        W_CAP   = 2'd2,
        W_REV   = 2'd3
    } walk_state_e;
endpackage

// File: rtl/sweep_regs.sv
module sweep_regs
    import sweep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [REG_AW-1:0]    addr_i,
    input  logic [ADDR_W-1:0]    wdata_i,
    input  logic [ADDR_W-1:0]    epoch_word_i,
    input  logic                 done_i,
    output logic                 go_o,
    output logic [ADDR_W-1:0]    from_o,
    output logic [ADDR_W-1:0]    upto_o,
    output logic [ADDR_W-1:0]    rdata_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] from;
        logic [ADDR_W-1:0] upto;
        logic              ien;
        logic              ist;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (we_i) begin
            case (addr_i)
                OFF_FROM:  d.from = wdata_i;
                OFF_UPTO:  d.upto = wdata_i;
                OFF_IEN:   d.ien  = wdata_i[0];
                OFF_ISTAT: if (!wdata_i[0]) d.ist = 1'b0;
                default: ;
            endcase
        end
        if (done_i) d.ist = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            OFF_FROM:  rdata_o = q.from;
            OFF_UPTO:  rdata_o = q.upto;
            OFF_EPOCH: rdata_o = epoch_word_i;
            OFF_ISTAT: rdata_o = {{(ADDR_W-1){1'b0}}, q.ist};
            OFF_IEN:   rdata_o = {{(ADDR_W-1){1'b0}}, q.ien};
            default:   rdata_o = '0;
        endcase
    end

    assign go_o   = we_i && (addr_i == OFF_GO) && wdata_i[0];
    assign from_o = q.from;
    assign upto_o = q.upto;
    assign irq_o  = q.ist & q.ien;

    AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> q.ist); // R7
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(done_i) || $past(we_i && addr_i == OFF_IEN))); // R8
endmodule

// File: rtl/sweep_walker.sv
module sweep_walker
    import sweep_pkg::*;
#(
    parameter int CAP_W    = 64,
    parameter int BASE_LSB = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic [ADDR_W-1:0]    from_i,
    input  logic [ADDR_W-1:0]    upto_i,
    output logic                 mem_req_o,
    output logic                 mem_we_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic [CAP_W-1:0]     mem_wdata_o,
    output logic                 mem_wtag_o,
    input  logic [CAP_W-1:0]     mem_rdata_i,
    input  logic                 mem_rtag_i,
    output logic                 rev_req_o,
    output logic [REV_AW-1:0]    rev_addr_o,
    input  logic [(1<<MAPW_LG)-1:0] rev_rdata_i,
    output logic                 running_o,
    output logic [ADDR_W-2:0]    epoch_o,
    output logic                 done_o
);
    localparam int GRAN_BYTES = 1 << GRAN_LG;

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] lim;
        logic [CAP_W-1:0]  cap;
        logic [ADDR_W-2:0] epoch;
    } walk_t;

    walk_t q, d;

    logic [ADDR_W-1:0] rd_base, held_base;
    logic [ADDR_W:0]   step;
    logic              hit;

    assign rd_base   = mem_rdata_i[BASE_LSB +: ADDR_W];
    assign held_base = q.cap[BASE_LSB +: ADDR_W];
    assign step      = {1'b0, q.cur} + GRAN_BYTES;
    assign hit       = rev_rdata_i[held_base[GRAN_LG +: MAPW_LG]];

    always_comb begin
        d          = q;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = q.cur;
        mem_wtag_o = 1'b0;
        rev_req_o  = 1'b0;
        rev_addr_o = '0;
        done_o     = 1'b0;
        case (q.st)
            W_IDLE: begin
                if (go_i) begin
                    d.st    = W_CHECK;
                    d.cur   = {from_i[ADDR_W-1:GRAN_LG], {GRAN_LG{1'b0}}};
                    d.lim   = upto_i;
                    d.epoch = q.epoch + 1'b1;
                end
            end
            W_CHECK: begin
                if (q.cur >= q.lim) begin
                    done_o  = 1'b1;
                    d.st    = W_IDLE;
                    d.epoch = q.epoch + 1'b1;
                end else begin
                    mem_req_o = 1'b1;
                    d.st      = W_CAP;
                end
            end
            W_CAP: begin
                if (mem_rtag_i) begin
                    rev_req_o  = 1'b1;
                    rev_addr_o = rd_base[ADDR_W-1 -: REV_AW];
                    d.cap      = mem_rdata_i;
                    d.st       = W_REV;
                end else begin
                    d.cur = step[ADDR_W-1:0];
                    if (step[ADDR_W]) d.lim = '0;
                    d.st  = W_CHECK;
                end
            end
            W_REV: begin
                if (hit) begin
                    mem_req_o = 1'b1;
                    mem_we_o  = 1'b1;
                end
                d.cur = step[ADDR_W-1:0];
                if (step[ADDR_W]) d.lim = '0;
                d.st  = W_CHECK;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: W_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_wdata_o = q.cap;
    assign running_o   = (q.st != W_IDLE);
    assign epoch_o     = q.epoch;

    AST_RUN_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !running_o) |=> running_o); // R3
    AST_EPOCH_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> (epoch_o == $past(epoch_o) + 1'b1)); // R3
    AST_GRANULE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[GRAN_LG-1:0] == '0)); // R4
    AST_WRITE_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($past(rev_req_o) && mem_addr_o == $past(mem_addr_o, 2))); // R5
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && running_o && !done_o) |=> $stable(epoch_o)); // R9
endmodule

// File: rtl/cap_sweep_engine.sv
module cap_sweep_engine
    import sweep_pkg::*;
#(
    parameter int CAP_W    = 64,
    parameter int BASE_LSB = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [CAP_W-1:0]     mem_wdata,
    output logic                 mem_wtag,
    input  logic [CAP_W-1:0]     mem_rdata,
    input  logic                 mem_rtag,
    output logic                 rev_req,
    output logic [REV_AW-1:0]    rev_addr,
    input  logic [(1<<MAPW_LG)-1:0] rev_rdata,
    output logic                 irq
);
    logic              go, done, running;
    logic [ADDR_W-1:0] from_addr, upto_addr;
    logic [ADDR_W-2:0] epoch;

    sweep_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (reg_we),
        .addr_i       (reg_addr),
        .wdata_i      (reg_wdata),
        .epoch_word_i ({epoch, running}),
        .done_i       (done),
        .go_o         (go),
        .from_o       (from_addr),
        .upto_o       (upto_addr),
        .rdata_o      (reg_rdata),
        .irq_o        (irq)
    );

    sweep_walker #(.CAP_W(CAP_W), .BASE_LSB(BASE_LSB)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .from_i      (from_addr),
        .upto_i      (upto_addr),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_wtag_o  (mem_wtag),
        .mem_rdata_i (mem_rdata),
        .mem_rtag_i  (mem_rtag),
        .rev_req_o   (rev_req),
        .rev_addr_o  (rev_addr),
        .rev_rdata_i (rev_rdata),
        .running_o   (running),
        .epoch_o     (epoch),
        .done_o      (done)
    );
endmodule

// File: tb/tb_cap_sweep_engine.sv
`timescale 1ns/1ps
module tb_cap_sweep_engine;
    localparam logic [31:0] MB = 32'h0000_2000;
    localparam int NG = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_wtag, mem_rtag, rev_req, irq;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic [23:0] rev_addr;
    logic [31:0] rev_rdata;

    logic [63:0] mdat [NG];
    logic        mtag [NG];
    logic [63:0] edat [NG];
    logic        etag [NG];
    logic [31:0] rmap [32];

    int vectors = 0, fails = 0, cyc = 0;
    int rd_cnt = 0, wr_cnt = 0, order_err = 0, oob = 0, rev_cnt = 0;
    logic [31:0] rd_next = '0;

    always #2 clk = ~clk;

    cap_sweep_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wtag(mem_wtag), .mem_rdata(mem_rdata), .mem_rtag(mem_rtag),
        .rev_req(rev_req), .rev_addr(rev_addr), .rev_rdata(rev_rdata), .irq(irq)
    );

    // memory and bitmap models, one-cycle read latency
    always @(posedge clk) begin
        if (rev_req) begin
            rev_rdata <= rmap[rev_addr[4:0]];
            rev_cnt   <= rev_cnt + 1;
        end
        if (mem_req) begin
            if (mem_addr < MB || mem_addr >= MB + NG*8) oob <= oob + 1;
            else if (mem_we) begin
                mdat[(mem_addr - MB) >> 3] <= mem_wdata;
                mtag[(mem_addr - MB) >> 3] <= mem_wtag;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mdat[(mem_addr - MB) >> 3];
                mem_rtag  <= mtag[(mem_addr - MB) >> 3];
                rd_cnt    <= rd_cnt + 1;
                if (mem_addr != rd_next) order_err <= order_err + 1;
                rd_next   <= mem_addr + 32'd8;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            vectors++; fails++;
            $display("FAIL watchdog (all requirements): cycles %0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // caller is in the low phase; write is captured at the next rising edge
    task automatic reg_wr(input logic [4:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_rd(5'd12, v);
            if (!v[0]) break;
        end
    endtask

    function automatic bit hit(input logic [31:0] base);
        return rmap[base[12:8]][base[7:3]];
    endfunction

    task automatic fill_random();
        for (int i = 0; i < NG; i++) begin
            logic [31:0] b;
            b = $urandom % 32'h2000;
            mdat[i] = {$urandom, b};
            mtag[i] = ($urandom % 4) != 0;
        end
        for (int j = 0; j < 32; j++) begin
            rmap[j] = (($urandom % 8) == 0) ? 32'hFFFF_FFFF : ($urandom & $urandom);
        end
    endtask

    task automatic run_sweep(input logic [31:0] from, input logic [31:0] upto, input string tag);
        int exp_rd = 0, exp_wr = 0, bad = 0;
        logic [31:0] v, e0;
        for (int i = 0; i < NG; i++) begin edat[i] = mdat[i]; etag[i] = mtag[i]; end
        for (logic [31:0] a = from & ~32'd7; a < upto; a += 32'd8) begin
            int k;
            k = (a - MB) >> 3;
            exp_rd++;
            if (etag[k] && hit(edat[k][31:0])) begin etag[k] = 1'b0; exp_wr++; end
        end
        rd_cnt = 0; wr_cnt = 0; order_err = 0; oob = 0;
        rd_next = from & ~32'd7;
        reg_rd(5'd12, e0);
        reg_wr(5'd0, from);
        reg_wr(5'd4, upto);
        reg_wr(5'd8, 32'd1);
        reg_rd(5'd12, v);
        chk(v[0] == 1'b1, "R3", {tag, " running after go"}, v[0], 1);
        chk(v[31:1] == e0[31:1] + 1, "R3", {tag, " epoch at start"}, v[31:1], e0[31:1] + 1);
        wait_idle();
        reg_rd(5'd12, v);
        chk(v[31:1] == e0[31:1] + 2, "R3", {tag, " epoch at finish"}, v[31:1], e0[31:1] + 2);
        chk(rd_cnt == exp_rd && order_err == 0 && oob == 0, "R4",
            {tag, " granule reads"}, rd_cnt, exp_rd);
        chk(wr_cnt == exp_wr, "R5", {tag, " tag clears written"}, wr_cnt, exp_wr);
        for (int i = 0; i < NG; i++) if (mdat[i] != edat[i] || mtag[i] != etag[i]) bad++;
        chk(bad == 0, "R6", {tag, " memory image after sweep"}, bad, 0);
        reg_rd(5'd16, v);
        chk(v == 32'd1, "R7", {tag, " status set on finish"}, v, 1);
    endtask

    initial begin
        logic [31:0] v, e0;
        void'($urandom(32'd20240601));
        rev_rdata = '0; mem_rdata = '0; mem_rtag = 1'b0;
        fill_random();
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a <= 20; a += 4) begin
            reg_rd(a[4:0], v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(irq == 1'b0, "R1", "irq during reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_rd(5'd12, v);
        chk(v == 0, "R1", "status word after reset", v, 0);
        chk(irq == 1'b0 && !mem_req && !rev_req, "R1", "quiet after reset", {mem_req, rev_req, irq}, 0);

        // R2 register readback
        reg_wr(5'd0, 32'h1234_5677);
        reg_wr(5'd4, 32'hCAFE_0008);
        reg_wr(5'd20, 32'hFFFF_FFFE);
        reg_rd(5'd0, v);  chk(v == 32'h1234_5677, "R2", "start readback", v, 32'h1234_5677);
        reg_rd(5'd4, v);  chk(v == 32'hCAFE_0008, "R2", "end readback", v, 32'hCAFE_0008);
        reg_rd(5'd20, v); chk(v == 0, "R2", "enable bit0 only", v, 0);
        reg_rd(5'd8, v);  chk(v == 0, "R2", "go reads zero", v, 0);
        reg_rd(5'd24, v); chk(v == 0, "R2", "unmapped reads zero", v, 0);

        // R10 empty range and R7 collision with acknowledge
        rd_cnt = 0; rev_cnt = 0;
        reg_rd(5'd12, e0);
        reg_wr(5'd0, MB + 32'h100);
        reg_wr(5'd4, MB + 32'h100);
        reg_wr(5'd8, 32'd1);
        reg_rd(5'd12, v);
        chk(v[0] == 1'b1, "R10", "running after empty go", v[0], 1);
        reg_wr(5'd16, 32'd0);
        reg_rd(5'd12, v);
        chk(v == {e0[31:1] + 31'd2, 1'b0}, "R10", "empty sweep finished", v, {e0[31:1] + 31'd2, 1'b0});
        chk(rd_cnt == 0 && rev_cnt == 0, "R10", "no access on empty range", rd_cnt + rev_cnt, 0);
        reg_rd(5'd16, v);
        chk(v == 1, "R7", "finish wins over same-cycle clear", v, 1);
        reg_wr(5'd16, 32'd0);
        reg_rd(5'd16, v);
        chk(v == 0, "R7", "clear by writing zero", v, 0);
        reg_wr(5'd0, MB + 32'h80);
        reg_wr(5'd4, MB + 32'h40);
        reg_wr(5'd8, 32'd1);
        wait_idle();
        reg_rd(5'd12, v);
        chk(v == {e0[31:1] + 31'd4, 1'b0}, "R10", "end below start", v, {e0[31:1] + 31'd4, 1'b0});
        reg_wr(5'd16, 32'd0);

        // directed: base zero kept, base in an all-ones bitmap word cleared
        mdat[63] = {32'hA5A5_0000, 32'h0000_0000}; mtag[63] = 1'b1;
        mdat[62] = {32'h5A5A_0000, 32'h0000_1FF0}; mtag[62] = 1'b1;
        rmap[0] = rmap[0] & ~32'd1;
        rmap[31] = 32'hFFFF_FFFF;
        run_sweep(MB, MB + NG*8, "full");
        chk(mtag[63] == 1'b1, "R6", "base zero unrevoked keeps tag", mtag[63], 1);
        chk(mtag[62] == 1'b0 && mdat[62] == {32'h5A5A_0000, 32'h0000_1FF0}, "R5",
            "revoked base cleared, data kept", {mtag[62], mdat[62][62:0]}, {1'b0, 63'h5A5A_0000_0000_1FF0});

        // R8 interrupt gating
        chk(irq == 1'b0, "R8", "irq masked while disabled", irq, 0);
        reg_wr(5'd20, 32'd1);
        chk(irq == 1'b1, "R8", "irq with status and enable", irq, 1);
        reg_wr(5'd16, 32'd1);
        chk(irq == 1'b1, "R7", "writing one keeps status", irq, 1);
        reg_wr(5'd16, 32'd0);
        chk(irq == 1'b0, "R8", "irq drops after clear", irq, 0);

        // R9 restart while running
        fill_random();
        rd_cnt = 0;
        reg_rd(5'd12, e0);
        reg_wr(5'd0, MB); reg_wr(5'd4, MB + NG*8); reg_wr(5'd8, 32'd1);
        repeat (5) @(negedge clk);
        reg_wr(5'd8, 32'd1);
        reg_rd(5'd12, v);
        chk(v == {e0[31:1] + 31'd1, 1'b1}, "R9", "epoch unchanged by restart", v, {e0[31:1] + 31'd1, 1'b1});
        wait_idle();
        chk(rd_cnt == NG, "R9", "sweep not restarted", rd_cnt, NG);
        reg_wr(5'd16, 32'd0);

        // randomised ranges, some with unaligned start
        for (int t = 0; t < 12; t++) begin
            logic [31:0] s, e;
            fill_random();
            s = MB + (($urandom % NG) << 3) + ((t % 3 == 0) ? ($urandom % 8) : 0);
            e = (s & ~32'd7) + 32'd8 + (($urandom % (NG - (((s & ~32'd7) - MB) >> 3))) << 3);
            run_sweep(s, e, "random");
            reg_wr(5'd16, 32'd0);
        end
        summary();
    end
endmodule